// File: doc/BRIEF.md
# Supply Window Qualifier

This block decides whether the input supply may be treated as good before a pass-transistor gate is allowed to turn on. It receives already-synchronized comparator flags, one set when the supply divider sits above the undervoltage trip and one set when it sits above the overvoltage trip. It also receives a lockout flag, which is high while the controller's own supply is healthy, and a slow timebase tick. From these it produces a registered supply-valid output that feeds the retry sequencer downstream.

The supply is inside its operating window when the undervoltage flag is high and the overvoltage flag is low. After lockout is released, the supply must stay inside the window for a full power-on dwell before supply-valid rises. Once valid, an excursion out of the window only clears supply-valid if it lasts for a filter time. The filter acts only on the faulting direction. A return into the window restores supply-valid at once, with no new dwell. The dwell and the filter always use the same length in ticks. That length comes from a built-in default or from a programmed count, chosen by a mode input.

Top module: `supply_window_qual`

## Requirements
- R1: While `uvlo_ok` is low, `supply_ok` is low on the clock edge after it is sampled, whatever the window flags and ticks do.
- R2: `supply_ok` is low out of reset. After `uvlo_ok` goes high, `supply_ok` rises on the clock edge that takes the N-th tick during which the supply has been continuously in the window. In the window means `above_uv`=1 and `above_ov`=0. N is the selected length.
- R3: If the window flags show out-of-window on any sampled cycle during the power-on dwell, the dwell count restarts from zero.
- R4: While `supply_ok` is high, an out-of-window excursion (`above_uv`=0 or `above_ov`=1) that returns before the N-th tick leaves `supply_ok` high. Each new excursion starts counting from zero.
- R5: An out-of-window excursion that lasts for N ticks clears `supply_ok` on the clock edge that takes the N-th tick.
- R6: After a filtered fault, `supply_ok` rises on the first clock edge at which the supply is back in the window, with no ticks needed.
- R7: With `use_default`=1 the length N is the parameter DEFAULT_TICKS. With `use_default`=0 it is `prog_ticks`. The same N is used for both the dwell and the filter.
- R8: A programmed count of zero acts as a length of one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | High while the controller supply is above lockout |
| above_uv | input | 1 | Undervoltage comparator: supply above the UV trip |
| above_ov | input | 1 | Overvoltage comparator: supply above the OV trip |
| tick | input | 1 | One-cycle timebase pulse |
| use_default | input | 1 | 1 selects the built-in length, 0 the programmed one |
| prog_ticks | input | CNT_W | Programmed dwell and filter length in ticks |
| supply_ok | output | 1 | Registered supply-valid |

## Verification
The dwell is driven with one tick short of N and then the full N, and it is also broken partway by an overvoltage blip. This separates a count that restarts from one that only pauses. Undervoltage and overvoltage excursions are each applied once as a short burst and once held through N ticks. The short burst is repeated back to back, which shows that filter progress does not carry over between excursions. A return into the window with no ticks, compared with a release from lockout, shows that only lockout release brings back the full dwell. Default mode, a programmed length and a programmed zero show which length was selected.

// File: rtl/swq_pkg.sv
package swq_pkg;
    typedef enum logic [2:0] {
        ST_LOCK  = 3'd0,
        ST_QUAL  = 3'd1,
        ST_GOOD  = 3'd2,
        ST_FILT  = 3'd3,
        ST_FAULT = 3'd4
    } swq_state_e;
endpackage

// File: rtl/swq_len_sel.sv
module swq_len_sel #(
    parameter int CNT_W         = 16,
    parameter int DEFAULT_TICKS = 5
) (
    input  logic             use_default,
    input  logic [CNT_W-1:0] prog_ticks,
    output logic [CNT_W-1:0] last_idx
);
    localparam logic [CNT_W-1:0] DEF_LAST = CNT_W'(DEFAULT_TICKS - 1);

    logic [CNT_W-1:0] prog_last;

    // zero behaves as a single tick (R8)
    always_comb begin
        if (prog_ticks == '0) prog_last = '0;
        else                  prog_last = prog_ticks - 1'b1;
    end

    assign last_idx = use_default ? DEF_LAST : prog_last;
endmodule

// File: rtl/swq_window.sv
module swq_window (
    input  logic above_uv,
    input  logic above_ov,
    output logic in_win
);
    assign in_win = above_uv & ~above_ov;
endmodule

// File: rtl/supply_window_qual.sv
module supply_window_qual #(
    parameter int CNT_W         = 16,
    parameter int DEFAULT_TICKS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_ok,
    input  logic             above_uv,
    input  logic             above_ov,
    input  logic             tick,
    input  logic             use_default,
    input  logic [CNT_W-1:0] prog_ticks,
    output logic             supply_ok
);
    import swq_pkg::*;

    typedef struct packed {
        swq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             ok;
    } swq_regs_t;

    swq_regs_t        r_d, r_q;
    logic             in_win;
    logic [CNT_W-1:0] last_idx;

    swq_len_sel #(.CNT_W(CNT_W), .DEFAULT_TICKS(DEFAULT_TICKS)) u_len (
        .use_default (use_default),
        .prog_ticks  (prog_ticks),
        .last_idx    (last_idx)
    );

    swq_window u_win (
        .above_uv (above_uv),
        .above_ov (above_ov),
        .in_win   (in_win)
    );

    always_comb begin
        r_d = r_q;
        if (!uvlo_ok) begin
            r_d.st  = ST_LOCK;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_LOCK: begin
                    r_d.st  = ST_QUAL;
                    r_d.cnt = '0;
                end
                ST_QUAL: begin
                    if (!in_win) begin
                        r_d.cnt = '0;
                    end else if (tick) begin
                        if (r_q.cnt == last_idx) begin
                            r_d.st  = ST_GOOD;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_GOOD: begin
                    if (!in_win) begin
                        r_d.st  = ST_FILT;
                        r_d.cnt = '0;
                    end
                end
                ST_FILT: begin
                    if (in_win) begin
                        r_d.st  = ST_GOOD;
                        r_d.cnt = '0;
                    end else if (tick) begin
                        if (r_q.cnt == last_idx) begin
                            r_d.st  = ST_FAULT;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_FAULT: begin
                    if (in_win) r_d.st = ST_GOOD;
                end
                default: begin
                    r_d.st  = ST_LOCK;
                    r_d.cnt = '0;
                end
            endcase
        end
        r_d.ok = (r_d.st == ST_GOOD) || (r_d.st == ST_FILT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_LOCK;
            r_q.cnt <= '0;
            r_q.ok  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign supply_ok = r_q.ok;

    p_lockout_forces_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok |=> !supply_ok);

    // R2, R6: a rise needs an in-window, unlocked cycle before it
    p_rise_needs_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |-> $past(in_win && uvlo_ok));

    // R5: a fall comes only from lockout or a tick taken while out of window
    p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_ok) |-> $past(!uvlo_ok || (tick && !in_win)));

    // R4, R6: valid and in window stays valid
    p_hold_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && in_win && uvlo_ok) |=> supply_ok);

    // R4: no tick out of window means no loss of valid
    p_no_tick_no_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && uvlo_ok && !tick) |=> supply_ok);
endmodule

// File: tb/supply_window_qual_tb.sv
module supply_window_qual_tb;
    localparam int CNT_W = 16;
    localparam int DEF_N = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             uvlo_ok = 1'b0;
    logic             above_uv = 1'b0;
    logic             above_ov = 1'b0;
    logic             tick = 1'b0;
    logic             use_default = 1'b0;
    logic [CNT_W-1:0] prog_ticks = 16'd3;
    logic             supply_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    supply_window_qual #(.CNT_W(CNT_W), .DEFAULT_TICKS(DEF_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .above_uv(above_uv),
        .above_ov(above_ov), .tick(tick), .use_default(use_default),
        .prog_ticks(prog_ticks), .supply_ok(supply_ok)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (supply_ok !== exp) begin
            n_bad++;
            $display("FAIL %s: supply_ok=%b expected %b at %0t", req, supply_ok, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // lockout release then full dwell of n ticks
    task automatic bring_up(input int n);
        uvlo_ok = 1'b0; step(1);
        above_uv = 1'b1; above_ov = 1'b0; uvlo_ok = 1'b1; step(1);
        ticks(n);
    endtask

    task automatic t_reset;
        chk("R2 reset", 1'b0);
    endtask

    task automatic t_lockout;
        above_uv = 1'b1; above_ov = 1'b0; uvlo_ok = 1'b0;
        ticks(6);
        chk("R1 lockout holds low", 1'b0);
        bring_up(3);
        chk("R2 up", 1'b1);
        uvlo_ok = 1'b0; step(1);
        chk("R1 lockout drops valid", 1'b0);
        uvlo_ok = 1'b1; step(1); ticks(2);
        chk("R1 release needs full dwell", 1'b0);
        ticks(1);
        chk("R2 dwell after release", 1'b1);
    endtask

    task automatic t_dwell;
        uvlo_ok = 1'b0; step(1);
        above_uv = 1'b1; uvlo_ok = 1'b1; step(1);
        ticks(2);
        chk("R2 one short of N", 1'b0);
        ticks(1);
        chk("R2 N-th tick", 1'b1);
    endtask

    task automatic t_restart;
        uvlo_ok = 1'b0; step(1);
        above_uv = 1'b1; uvlo_ok = 1'b1; step(1);
        ticks(2);
        above_ov = 1'b1; step(1); above_ov = 1'b0;
        ticks(2);
        chk("R3 restarted count", 1'b0);
        ticks(1);
        chk("R3 full count after restart", 1'b1);
    endtask

    task automatic t_short_glitch;
        bring_up(3);
        above_uv = 1'b0; ticks(2); above_uv = 1'b1; step(1);
        chk("R4 short UV glitch ignored", 1'b1);
        above_uv = 1'b0; ticks(2);
        chk("R4 second glitch restarts filter", 1'b1);
        above_uv = 1'b1; step(1);
        above_ov = 1'b1; ticks(2); above_ov = 1'b0; step(1);
        chk("R4 short OV glitch ignored", 1'b1);
    endtask

    task automatic t_fault_recover;
        bring_up(3);
        above_uv = 1'b0; ticks(3);
        chk("R5 UV fault after N", 1'b0);
        above_uv = 1'b1; step(1);
        chk("R6 immediate UV recovery", 1'b1);
        above_ov = 1'b1; ticks(3);
        chk("R5 OV fault after N", 1'b0);
        above_ov = 1'b0; step(1);
        chk("R6 immediate OV recovery", 1'b1);
    endtask

    task automatic t_default;
        use_default = 1'b1;
        bring_up(4);
        chk("R7 default one short", 1'b0);
        ticks(1);
        chk("R7 default N", 1'b1);
        above_uv = 1'b0; ticks(4);
        chk("R7 default filter one short", 1'b1);
        ticks(1);
        chk("R7 default filter N", 1'b0);
        above_uv = 1'b1; step(1);
        use_default = 1'b0;
    endtask

    task automatic t_zero;
        prog_ticks = '0;
        bring_up(1);
        chk("R8 zero acts as one tick", 1'b1);
        prog_ticks = 16'd3;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1; step(1);
        t_reset();
        t_lockout();
        t_dwell();
        t_restart();
        t_short_glitch();
        t_fault_recover();
        t_default();
        t_zero();
        finish_run();
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        finish_run();
    end
endmodule